// File: doc/BRIEF.md
# Graphics Device Supply Rail Sequencer

This block powers a discrete graphics device's five supply rails up or down as one fixed, ordered sequence. It drives one enable per rail, a combined "every rail is good" indication and an active-low device reset. It also watches one power-good input per rail. A single-cycle power-on strobe starts the ramp-up. A single-cycle power-off strobe starts the ramp-down. While a sequence runs, the block reports busy. When it ends, the block pulses done for one cycle.

Every wait is measured with a cycle counter. Millisecond parameters are scaled by a ticks-per-millisecond parameter, so a short test can use small values. If a rail does not reach the expected power-good level within its window, the block sets a sticky error and records which rail failed. It then goes on with the sequence, so every sequence ends.

Rail index numbering, used by the enable, power-good and fault-index ports:
- 0 is the 1.8 V auxiliary rail.
- 1 is the 3.3 V rail.
- 2 is the core rail.
- 3 is the PCIe rail.
- 4 is the framebuffer rail.

Top module: `gpu_rail_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the outputs are as follows. rail_en is 0, all_good is 0, dev_rst_n is 0, busy is 0, done is 0 and fault is 0. The block is idle.
- R2: A power-on strobe taken while idle drives dev_rst_n low. It then sets rail_en bits in the order 0,1,2,3,4. Bit i+1 is set only after pg_in[i] reads 1 or that rail's window has run out. rail_en therefore always has the form of contiguous ones from bit 0.
- R3: Power-down clears the rail_en bits in the order 4,3,2,1,0. Each next step waits for the cleared rail's pg_in to read 0 or for its window to run out.
- R4: After the last rail step, all_good rises while dev_rst_n is still 0. dev_rst_n then rises exactly SETTLE_MS*TICKS_PER_MS+1 cycles later, in the same cycle as done.
- R5: A power-off strobe drives dev_rst_n low at once. all_good falls exactly HOLD_MS*TICKS_PER_MS+1 cycles later, while all five enables are still set, and before any enable is cleared.
- R6: A rail that never reaches its power-good level delays the next step by its window plus 2 cycles. The next step is the next enable set or cleared. On power-up the window is UP_SLOW_MS ticks for rails 0 and 1 and UP_FAST_MS ticks for rails 2 to 4. On power-down it is DN_MS ticks.
- R7: An expired window sets fault and loads fail_rail with that rail's index. Of several failures, the last one is kept. Both hold until the next accepted command clears them.
- R8: A strobe that arrives while busy is ignored. It starts no further sequence and changes no output.
- R9: done is high for exactly one cycle at the end of each sequence.
- R10: If both strobes arrive in the same idle cycle, power-on is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_req | input | 1 | Single-cycle power-on strobe |
| pwr_off_req | input | 1 | Single-cycle power-off strobe |
| pg_in | input | 5 | Per-rail power-good, index as listed above |
| rail_en | output | 5 | Per-rail enable |
| all_good | output | 1 | Every rail is up and good |
| dev_rst_n | output | 1 | Active-low device reset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fault | output | 1 | Sticky window-expired flag |
| fail_rail | output | 3 | Index of the last rail whose window expired |

## Verification
Each result is due a fixed number of cycles after its cause:
- the device reset release follows the combined-good rise by the settle ticks plus 1;
- the combined-good fall follows the power-off strobe by the hold ticks plus 1;
- the step after a stuck rail follows that rail's enable change by its window plus 2.

The bench time-stamps every edge of these outputs at the falling clock edge. It compares the differences with these counts, computed from the parameters. The end-of-sequence values are read only after done has been seen.

// File: rtl/gpu_rail_pkg.sv
// Shared constants and state encoding for the rail sequencer.
// Assumes exactly five rails, numbered in power-up order.
package gpu_rail_pkg;
    localparam int unsigned RAILS = 5;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned SLOW_RAILS = 2;   // lowest-index rails using the long up window

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_EN,
        ST_UP_WAIT,
        ST_UP_SETTLE,
        ST_DN_HOLD,
        ST_DN_EN,
        ST_DN_WAIT
    } seq_state_t;
endpackage

// File: rtl/gpu_rail_timer.sv
// Loadable down-counter used for every wait window.
// Assumes load values are nonzero; expired is high while the count is zero.
module gpu_rail_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R6: the window only shrinks unless reloaded
    assert_cnt_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/gpu_rail_fault.sv
// Sticky window-expired flag with the index of the last failing rail.
// Assumes clear and set never coincide.
module gpu_rail_fault #(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic [IDX_W-1:0] set_idx,
    output logic             fault,
    output logic [IDX_W-1:0] fail_idx
);
    // Hold the flag until the next accepted command clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault    <= 1'b0;
            fail_idx <= '0;
        end else if (clr) begin
            fault    <= 1'b0;
            fail_idx <= '0;
        end else if (set) begin
            fault    <= 1'b1;
            fail_idx <= set_idx;
        end
    end

    // R7: the flag only rises because a window expired
    assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(set));
endmodule

// File: rtl/gpu_rail_seq.sv
// Ordered supply-rail sequencer for a discrete graphics device.
// Power-up: reset low, rails 0..4 each enabled and awaited, combined-good, settle, reset high.
// Power-down: reset low, hold, combined-good low, rails 4..0 each cleared and awaited.
// Assumes pg_in is already synchronous to clk and strobes last one cycle.
module gpu_rail_seq
    import gpu_rail_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 50000,
    parameter int unsigned UP_SLOW_MS   = 20,
    parameter int unsigned UP_FAST_MS   = 5,
    parameter int unsigned DN_MS        = 20,
    parameter int unsigned SETTLE_MS    = 1,
    parameter int unsigned HOLD_MS      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_on_req,
    input  logic                 pwr_off_req,
    input  logic [RAILS-1:0]     pg_in,
    output logic [RAILS-1:0]     rail_en,
    output logic                 all_good,
    output logic                 dev_rst_n,
    output logic                 busy,
    output logic                 done,
    output logic                 fault,
    output logic [IDX_W-1:0]     fail_rail
);
    localparam int unsigned MAX_MS_A  = (UP_SLOW_MS > UP_FAST_MS) ? UP_SLOW_MS : UP_FAST_MS;
    localparam int unsigned MAX_MS_B  = (DN_MS > HOLD_MS) ? DN_MS : HOLD_MS;
    localparam int unsigned MAX_MS_C  = (MAX_MS_A > MAX_MS_B) ? MAX_MS_A : MAX_MS_B;
    localparam int unsigned MAX_MS    = (MAX_MS_C > SETTLE_MS) ? MAX_MS_C : SETTLE_MS;
    localparam int unsigned MAX_TICKS = MAX_MS * TICKS_PER_MS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam int unsigned SLOTS     = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RAILS - 1);
    localparam logic [CNT_W-1:0] DN_TICKS     = CNT_W'(DN_MS * TICKS_PER_MS);
    localparam logic [CNT_W-1:0] SETTLE_TICKS = CNT_W'(SETTLE_MS * TICKS_PER_MS);
    localparam logic [CNT_W-1:0] HOLD_TICKS   = CNT_W'(HOLD_MS * TICKS_PER_MS);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] up_lim [SLOTS];
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             start_on, start_off;
    logic             up_step, dn_step, up_fail, dn_fail;

    // Per-rail power-up windows: long for the first rails, short for the rest.
    for (genvar g = 0; g < SLOTS; g++) begin : g_up_lim
        if (g < SLOW_RAILS) begin : g_slow
            assign up_lim[g] = CNT_W'(UP_SLOW_MS * TICKS_PER_MS);
        end else begin : g_fast
            assign up_lim[g] = CNT_W'(UP_FAST_MS * TICKS_PER_MS);
        end
    end

    // Decode command acceptance and step conditions.
    always_comb begin
        start_on  = (state == ST_IDLE) && pwr_on_req;
        start_off = (state == ST_IDLE) && !pwr_on_req && pwr_off_req;
        up_fail   = (state == ST_UP_WAIT) && !pg_in[idx] && tmr_exp;
        dn_fail   = (state == ST_DN_WAIT) && pg_in[idx] && tmr_exp;
        up_step   = (state == ST_UP_WAIT) && (pg_in[idx] || tmr_exp);
        dn_step   = (state == ST_DN_WAIT) && (!pg_in[idx] || tmr_exp);
    end

    // Select which window, if any, is loaded this cycle.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == ST_UP_EN) begin
            tmr_load = 1'b1;
            tmr_val  = up_lim[idx];
        end else if (up_step && idx == LAST) begin
            tmr_load = 1'b1;
            tmr_val  = SETTLE_TICKS;
        end else if (start_off) begin
            tmr_load = 1'b1;
            tmr_val  = HOLD_TICKS;
        end else if (state == ST_DN_EN) begin
            tmr_load = 1'b1;
            tmr_val  = DN_TICKS;
        end
    end

    gpu_rail_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    gpu_rail_fault #(.IDX_W(IDX_W)) i_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_on || start_off),
        .set      (up_fail || dn_fail),
        .set_idx  (idx),
        .fault    (fault),
        .fail_idx (fail_rail)
    );

    // Main sequence: step through rails and drive reset and combined-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            rail_en   <= '0;
            all_good  <= 1'b0;
            dev_rst_n <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_on) begin
                        dev_rst_n <= 1'b0;
                        idx       <= '0;
                        state     <= ST_UP_EN;
                    end else if (start_off) begin
                        dev_rst_n <= 1'b0;
                        state     <= ST_DN_HOLD;
                    end
                end
                ST_UP_EN: begin
                    rail_en[idx] <= 1'b1;
                    state        <= ST_UP_WAIT;
                end
                ST_UP_WAIT: begin
                    if (up_step) begin
                        if (idx == LAST) begin
                            all_good <= 1'b1;
                            state    <= ST_UP_SETTLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_UP_EN;
                        end
                    end
                end
                ST_UP_SETTLE: begin
                    if (tmr_exp) begin
                        dev_rst_n <= 1'b1;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_DN_HOLD: begin
                    if (tmr_exp) begin
                        all_good <= 1'b0;
                        idx      <= LAST;
                        state    <= ST_DN_EN;
                    end
                end
                ST_DN_EN: begin
                    rail_en[idx] <= 1'b0;
                    state        <= ST_DN_WAIT;
                end
                ST_DN_WAIT: begin
                    if (dn_step) begin
                        if (idx == '0) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx - 1'b1;
                            state <= ST_DN_EN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R2 / R3: enables always form contiguous ones from rail 0
    assert_en_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_en & (rail_en + 1'b1)) == '0));
    // R4: device reset released only with every rail up and good
    assert_rst_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_n |-> (all_good && rail_en == '1));
    // R5: combined-good never stands with a rail off
    assert_good_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_good |-> (rail_en == '1));
    // R9: done is a one-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a strobe while busy leaves the block busy or finishing
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (pwr_on_req || pwr_off_req) && !done) |=> (busy || done));
endmodule

// File: tb/test_gpu_rail_seq.sv
module test_gpu_rail_seq;
    localparam int unsigned T    = 10;
    localparam int unsigned SLOW = 20 * T;
    localparam int unsigned FAST = 5 * T;
    localparam int unsigned SETL = 1 * T;
    localparam int unsigned HOLD = 5 * T;
    localparam int unsigned PGD  = 3;

    typedef struct packed {
        logic       op_on;
        logic [4:0] lo;
        logic [4:0] hi;
        logic [4:0] en;
        logic       good;
        logic       rstn;
        logic       err;
        logic [2:0] fidx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b0, 3'd0},
        '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0},
        '{1'b1, 5'b00100, 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 3'd2},
        '{1'b0, 5'b00000, 5'b01000, 5'b00000, 1'b0, 1'b0, 1'b1, 3'd3},
        '{1'b1, 5'b10001, 5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 3'd4},
        '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, on_req = 1'b0, off_req = 1'b0;
    logic [4:0] pg, rail_en, lo_m = '0, hi_m = '0;
    logic all_good, dev_rst_n, busy, done, fault;
    logic [2:0] fail_rail;
    logic [4:0] dly [PGD];
    int checks = 0, errors = 0, cyc = 0;
    int done_cnt = 0, order_viol = 0, long_done = 0;
    int t_good_up, t_good_dn, t_rst_up, t_rst_dn;
    int t_rise [5];
    int t_fall [5];
    logic [4:0] en_at_good_dn;
    logic p_good = 0, p_rst = 0, p_done = 0;
    logic [4:0] p_en = '0;

    always #10 clk = ~clk;

    gpu_rail_seq #(.TICKS_PER_MS(T)) i_gpu_rail_seq (
        .clk(clk), .rst_n(rst_n), .pwr_on_req(on_req), .pwr_off_req(off_req),
        .pg_in(pg), .rail_en(rail_en), .all_good(all_good), .dev_rst_n(dev_rst_n),
        .busy(busy), .done(done), .fault(fault), .fail_rail(fail_rail)
    );

    // Rail model: power-good follows the enable after PGD cycles unless forced.
    always_ff @(posedge clk) begin
        dly[0] <= rail_en;
        for (int k = 1; k < PGD; k++) dly[k] <= dly[k-1];
        cyc <= cyc + 1;
    end
    assign pg = (dly[PGD-1] & ~lo_m) | hi_m;

    // Monitor: time-stamp output edges at the falling clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((rail_en & (rail_en + 5'd1)) != 5'd0) order_viol++;
            if (done) done_cnt++;
            if (done && p_done) long_done++;
            if (all_good && !p_good) t_good_up = cyc;
            if (!all_good && p_good) begin t_good_dn = cyc; en_at_good_dn = rail_en; end
            if (dev_rst_n && !p_rst) t_rst_up = cyc;
            if (!dev_rst_n && p_rst) t_rst_dn = cyc;
            for (int k = 0; k < 5; k++) begin
                if (rail_en[k] && !p_en[k]) t_rise[k] = cyc;
                if (!rail_en[k] && p_en[k]) t_fall[k] = cyc;
            end
        end
        p_good = all_good; p_rst = dev_rst_n; p_done = done; p_en = rail_en;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic on, input logic off);
        @(negedge clk); on_req = on; off_req = off;
        @(negedge clk); on_req = 1'b0; off_req = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 3000; n++) begin
            if (done) return;
            @(negedge clk);
        end
        chk(1'b0, "wait_done", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0, gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rail_en == 0 && !all_good && !dev_rst_n && !busy && !done && !fault,
            "R1 reset state", rail_en, 0);

        // Vector table walk (R2 R3 R7)
        for (int v = 0; v < NV; v++) begin
            lo_m = VEC[v].lo; hi_m = VEC[v].hi;
            strobe(VEC[v].op_on, !VEC[v].op_on);
            wait_done();
            @(negedge clk);
            chk(rail_en == VEC[v].en, "R2/R3 final enables", rail_en, VEC[v].en);
            chk(all_good == VEC[v].good && dev_rst_n == VEC[v].rstn,
                "R4/R5 final good/reset", {all_good, dev_rst_n}, {VEC[v].good, VEC[v].rstn});
            chk(fault == VEC[v].err && (!VEC[v].err || fail_rail == VEC[v].fidx),
                "R7 fault/fail_rail", {fault, fail_rail}, {VEC[v].err, VEC[v].fidx});
        end
        lo_m = '0; hi_m = '0;

        // R2 R4: clean power-up order and settle gap
        strobe(1'b1, 1'b0); wait_done(); @(negedge clk);
        chk(t_rst_up - t_good_up == SETL + 1, "R4 settle gap", t_rst_up - t_good_up, SETL + 1);
        chk(t_rise[0] < t_rise[1] && t_rise[1] < t_rise[2] && t_rise[2] < t_rise[3]
            && t_rise[3] < t_rise[4] && t_rise[4] < t_good_up, "R2 up order", t_rise[4], t_good_up);

        // R3 R5: clean power-down
        strobe(1'b0, 1'b1); wait_done(); @(negedge clk);
        chk(t_good_dn - t_rst_dn == HOLD + 1, "R5 hold gap", t_good_dn - t_rst_dn, HOLD + 1);
        chk(en_at_good_dn == 5'h1F, "R5 rails on at good fall", en_at_good_dn, 5'h1F);
        chk(t_fall[4] < t_fall[3] && t_fall[3] < t_fall[2] && t_fall[2] < t_fall[1]
            && t_fall[1] < t_fall[0] && t_good_dn < t_fall[4], "R3 down order", t_fall[4], t_fall[0]);

        // R6: slow rail 1 and fast rail 2 both stuck low
        lo_m = 5'b00110;
        strobe(1'b1, 1'b0); wait_done(); @(negedge clk);
        chk(t_rise[2] - t_rise[1] == SLOW + 2, "R6 slow window", t_rise[2] - t_rise[1], SLOW + 2);
        chk(t_rise[3] - t_rise[2] == FAST + 2, "R6 fast window", t_rise[3] - t_rise[2], FAST + 2);
        chk(fault && fail_rail == 3'd2, "R7 last failure kept", fail_rail, 2);
        lo_m = '0;

        // R6: down window with rail 3 stuck high
        hi_m = 5'b01000;
        strobe(1'b0, 1'b1); wait_done(); @(negedge clk);
        chk(t_fall[2] - t_fall[3] == 20 * T + 2, "R6 down window", t_fall[2] - t_fall[3], 20 * T + 2);
        hi_m = '0;

        // R10: both strobes in idle -> power-on
        strobe(1'b1, 1'b1); wait_done(); @(negedge clk);
        chk(rail_en == 5'h1F && dev_rst_n, "R10 on wins", rail_en, 5'h1F);
        chk(!fault, "R7 fault cleared on command", fault, 0);

        // R8 R9: strobes while busy are ignored
        strobe(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        d0 = done_cnt;
        wait_done();
        repeat (300) @(negedge clk);
        chk(done_cnt - d0 == 1, "R8 single sequence", done_cnt - d0, 1);
        chk(rail_en == 0 && !busy, "R8 no extra sequence", rail_en, 0);
        chk(long_done == 0, "R9 done width", long_done, 0);
        chk(order_viol == 0, "R2 contiguous enables", order_viol, 0);

        // R1: reset in the middle of power-up
        strobe(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        gap = busy;
        chk(rail_en == 0 && !all_good && !dev_rst_n && gap == 0 && !fault,
            "R1 mid-sequence reset", rail_en, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule